// File: doc/BRIEF.md
# Attribute-Selected Glyph Pixel Pipeline

This block turns a character code and its attribute byte into the coloured pixels of one text cell. Glyph rows come from an external 32 KB font store that is read without wait states. The store holds sixteen 2 KB font slots. A two-bit group value, held in a small control register, selects a bank of four slots. Each character then picks one of those four slots through two of its own attribute bits. A display can therefore show four different fonts at once, and a 4 KB font can span two neighbouring slots.

For every cell the block forms the font address from the slot, the character code and the glyph row. On the last pixel of the current cell it captures the font byte and the attribute colours. It then shifts the byte out, most significant bit first, as the cell that follows. Set bits take the foreground colour and clear bits take the background colour. Both colours are three-bit values that expand to full-intensity 4-bit red, green and blue channels. A mode bit in the control register chooses between a 40-column and an 80-column pixel rate. The block brings out a pixel strobe that marks each pixel step. Cells flagged as outside the active area show black.

Top module: `glyph_pixel_pipe`

## Requirements
- R1: After reset the group is 0, the block runs in 40-column mode and the RGB outputs are all zero.
- R2: `cg_addr` = (group*4 + {attr[7],attr[3]})*2048 + char_code*8 + glyph_row. It is combinational from the current inputs and the group register.
- R3: With the group and attr[7] fixed, toggling attr[3] moves `cg_addr` by exactly 2048. This selects the two halves of a 4 KB font held in neighbouring slots.
- R4: A cycle with `ctrl_we` high loads the group from `ctrl_din[1:0]` and the 80-column flag from `ctrl_din[7]`. Bits 6:2 have no effect. Without `ctrl_we` both values hold.
- R5: A cell's font byte is shown most significant bit first, one bit for each pixel step.
- R6: The foreground colour is attr[6:4] and the background colour is attr[2:0]. In each colour, bit 0 is blue, bit 1 is red and bit 2 is green. A set colour bit drives its channel to 0xF and a clear bit drives it to 0x0.
- R7: In 40-column mode `pix_stb` is high on every second clock. In 80-column mode it is high on every clock.
- R8: A cell captured while `cell_active` is low outputs black on all eight pixels.
- R9: Pixel steps are counted in groups of eight from reset. The eighth step of each group loads the font byte, the colours and the active flag from the inputs present at that step. These values are shown as the next cell.
- R10: Changes to the character inputs after a cell has been captured do not alter the pixels of that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_din | input | 8 | Control data: [1:0] group, [7] 80-column |
| cell_active | input | 1 | Cell lies inside the display area |
| char_code | input | 8 | Character code of the next cell |
| char_attr | input | 8 | Attribute byte of the next cell |
| glyph_row | input | 3 | Row within the glyph |
| cg_addr | output | 15 | Font store address |
| cg_data | input | 8 | Font store read data |
| pix_stb | output | 1 | Pixel step strobe |
| red | output | 4 | Red channel |
| grn | output | 4 | Green channel |
| blu | output | 4 | Blue channel |

## Verification
The font address has no register in its path, so the bench checks it shortly after it drives the character inputs, in the same cycle. Pixels pass through one register stage. The bench keeps its own count of strobed clocks from reset and so finds the capturing edge: the eighth strobe of a group. It expects pixel 0 right after that edge and pixel p after p more strobed edges. Every sample is taken at a falling edge. After each capture the bench scrambles the character inputs, and a control write shows its effect on the strobe rate from the next cycle.

// File: rtl/cgp_pkg.sv
package cgp_pkg;
  localparam int CGP_CODE_W = 8;
  localparam int CGP_ROW_W  = 3;
  localparam int CGP_GRP_W  = 2;
  localparam int CGP_SEL_W  = 2;
  localparam int CGP_PIX_W  = 8;
  localparam int CGP_CH_W   = 4;
  localparam int CGP_SLOT_W = CGP_GRP_W + CGP_SEL_W;
  localparam int CGP_ADDR_W = CGP_SLOT_W + CGP_CODE_W + CGP_ROW_W;

  typedef logic [2:0] colour3_t;

  typedef struct packed {
    logic [CGP_CH_W-1:0] r;
    logic [CGP_CH_W-1:0] g;
    logic [CGP_CH_W-1:0] b;
  } rgb_t;

  // slot = group * 4 + {high select, low select}
  function automatic logic [CGP_SLOT_W-1:0] slot_of(
    input logic [CGP_GRP_W-1:0] grp, input logic sel_hi, input logic sel_lo);
    return {grp, sel_hi, sel_lo};
  endfunction

  // address = slot * 2048 + code * 8 + row
  function automatic logic [CGP_ADDR_W-1:0] calc_font_addr(
    input logic [CGP_SLOT_W-1:0] slot, input logic [CGP_CODE_W-1:0] code,
    input logic [CGP_ROW_W-1:0] row);
    return {slot, code, row};
  endfunction

  // colour bit 0 blue, bit 1 red, bit 2 green; full intensity channels
  function automatic rgb_t expand(input colour3_t c);
    rgb_t o;
    o.r = {CGP_CH_W{c[1]}};
    o.g = {CGP_CH_W{c[2]}};
    o.b = {CGP_CH_W{c[0]}};
    return o;
  endfunction
endpackage

// File: rtl/cg_ctrl_reg.sv
module cg_ctrl_reg
  import cgp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CGP_GRP_W-1:0] grp_in,
  input  logic                 wide_in,
  output logic [CGP_GRP_W-1:0] grp,
  output logic                 wide
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp  <= '0;
      wide <= 1'b0;
    end else if (we) begin
      grp  <= grp_in;
      wide <= wide_in;
    end
  end

  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(grp) && $stable(wide)));
  p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (grp == $past(grp_in) && wide == $past(wide_in)));
endmodule

// File: rtl/cg_pix_timer.sv
module cg_pix_timer #(
  parameter int PIX_PER_CELL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide,
  output logic step,
  output logic last
);
  localparam int CNT_W = $clog2(PIX_PER_CELL);

  logic             ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  assign step = wide | ph;
  assign last = (cnt == CNT_W'(PIX_PER_CELL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= last ? '0 : cnt + 1'b1;
  end

  p_step_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && step) |=> (wide || !step));
endmodule

// File: rtl/cg_font_addr.sv
module cg_font_addr
  import cgp_pkg::*;
(
  input  logic [CGP_GRP_W-1:0]  grp,
  input  logic                  sel_hi,
  input  logic                  sel_lo,
  input  logic [CGP_CODE_W-1:0] code,
  input  logic [CGP_ROW_W-1:0]  row,
  output logic [CGP_ADDR_W-1:0] addr
);
  assign addr = calc_font_addr(slot_of(grp, sel_hi, sel_lo), code, row);
endmodule

// File: rtl/cg_pix_shifter.sv
module cg_pix_shifter
  import cgp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 last,
  input  logic [CGP_PIX_W-1:0] font_row,
  input  colour3_t             fg_in,
  input  colour3_t             bg_in,
  input  logic                 active,
  output rgb_t                 pix
);
  logic [CGP_PIX_W-1:0] sreg;
  colour3_t             fg_q, bg_q;
  logic                 act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg  <= '0;
      fg_q  <= '0;
      bg_q  <= '0;
      act_q <= 1'b0;
    end else if (step) begin
      if (last) begin
        sreg  <= font_row;
        fg_q  <= fg_in;
        bg_q  <= bg_in;
        act_q <= active;
      end else begin
        sreg <= {sreg[CGP_PIX_W-2:0], 1'b0};
      end
    end
  end

  assign pix = act_q ? expand(sreg[CGP_PIX_W-1] ? fg_q : bg_q) : '0;

  p_shift_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (sreg[CGP_PIX_W-1] == $past(sreg[CGP_PIX_W-2])));
  p_attr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(fg_q) && $stable(bg_q) && $stable(act_q) && $stable(sreg)));
  p_load_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (sreg == $past(font_row)));
endmodule

// File: rtl/glyph_pixel_pipe.sv
module glyph_pixel_pipe
  import cgp_pkg::*;
#(
  parameter int PIX_PER_CELL = CGP_PIX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic [7:0]            ctrl_din,
  input  logic                  cell_active,
  input  logic [CGP_CODE_W-1:0] char_code,
  input  logic [7:0]            char_attr,
  input  logic [CGP_ROW_W-1:0]  glyph_row,
  output logic [CGP_ADDR_W-1:0] cg_addr,
  input  logic [CGP_PIX_W-1:0]  cg_data,
  output logic                  pix_stb,
  output logic [CGP_CH_W-1:0]   red,
  output logic [CGP_CH_W-1:0]   grn,
  output logic [CGP_CH_W-1:0]   blu
);
  logic [CGP_GRP_W-1:0] grp_w;
  logic                 wide_w;
  logic                 step_w, last_w;
  rgb_t                 pix_w;
  logic                 unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_din[6:2];

  cg_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we),
    .grp_in(ctrl_din[CGP_GRP_W-1:0]), .wide_in(ctrl_din[7]),
    .grp(grp_w), .wide(wide_w)
  );

  cg_pix_timer #(.PIX_PER_CELL(PIX_PER_CELL)) u_timer (
    .clk(clk), .rst_n(rst_n), .wide(wide_w), .step(step_w), .last(last_w)
  );

  cg_font_addr u_addr (
    .grp(grp_w), .sel_hi(char_attr[7]), .sel_lo(char_attr[3]),
    .code(char_code), .row(glyph_row), .addr(cg_addr)
  );

  cg_pix_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .step(step_w), .last(last_w),
    .font_row(cg_data), .fg_in(char_attr[6:4]), .bg_in(char_attr[2:0]),
    .active(cell_active), .pix(pix_w)
  );

  assign pix_stb = step_w;
  assign red     = pix_w.r;
  assign grn     = pix_w.g;
  assign blu     = pix_w.b;

  p_slot_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cg_addr[CGP_ADDR_W-1 -: CGP_SLOT_W] == {grp_w, char_attr[7], char_attr[3]});
endmodule

// File: tb/test_glyph_pixel_pipe.sv
module test_glyph_pixel_pipe;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_din = '0;
  logic        cell_active = 1'b0;
  logic [7:0]  char_code = '0;
  logic [7:0]  char_attr = '0;
  logic [2:0]  glyph_row = '0;
  logic [14:0] cg_addr;
  logic [7:0]  cg_data;
  logic        pix_stb;
  logic [3:0]  red, grn, blu;

  int checks = 0;
  int errors = 0;
  logic [2:0] bcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_pixel_pipe i_glyph_pixel_pipe (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_din(ctrl_din),
    .cell_active(cell_active), .char_code(char_code), .char_attr(char_attr),
    .glyph_row(glyph_row), .cg_addr(cg_addr), .cg_data(cg_data),
    .pix_stb(pix_stb), .red(red), .grn(grn), .blu(blu)
  );

  function automatic logic [7:0] rom_model(input logic [14:0] a);
    return a[7:0] ^ {a[14:11], a[10:7]} ^ 8'h5A;
  endfunction

  assign cg_data = rom_model(cg_addr);

  // strobed clocks counted since reset (R9)
  always_ff @(posedge clk) begin
    if (!rst_n)       bcnt <= '0;
    else if (pix_stb) bcnt <= bcnt + 3'd1;
  end

  function automatic int exp_addr(input int g, input logic [7:0] at,
                                  input logic [7:0] code, input logic [2:0] row);
    return (g * 4 + at[7] * 2 + at[3]) * 2048 + code * 8 + row;
  endfunction

  function automatic logic [11:0] colour12(input logic [2:0] c);
    return {c[1] ? 4'hF : 4'h0, c[2] ? 4'hF : 4'h0, c[0] ? 4'hF : 4'h0};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; checks the address, waits for capture, checks 8 pixels
  task automatic show_cell(input logic [7:0] code, input logic [7:0] at,
                           input logic [2:0] row, input logic act, input int g,
                           input string tag);
    logic [7:0] pat;
    int ea;
    char_code = code; char_attr = at; glyph_row = row; cell_active = act;
    #1;
    ea = exp_addr(g, at, code, row);
    chk({tag, " R2 address"}, int'(cg_addr), ea);
    pat = rom_model(15'(ea));
    while (!(pix_stb && bcnt == 3'd7)) @(negedge clk);
    @(posedge clk);
    #1;
    char_attr = ~at; char_code = ~code; cell_active = ~act; // R10 scramble
    @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      logic [11:0] e;
      if (p > 0) begin
        while (!pix_stb) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
      end
      e = !act ? 12'h000 : (pat[7-p] ? colour12(at[6:4]) : colour12(at[2:0]));
      chk({tag, " R5 R6 R8 R9 R10 pixel"}, int'({red, grn, blu}), int'(e));
    end
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    ctrl_we = 1'b1; ctrl_din = d;
    @(posedge clk);
    #1 ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rate_check(input logic wide, input string tag);
    logic a, b;
    a = pix_stb;
    @(negedge clk);
    b = pix_stb;
    if (wide) chk({tag, " R7 strobe every clock"}, int'({a, b}), 2'b11);
    else      chk({tag, " R7 strobe alternates"}, int'(a ^ b), 1);
  endtask

  task automatic t_reset;
    chk("R1 black after reset", int'({red, grn, blu}), 0);
    char_attr = 8'h88; char_code = 8'h41; glyph_row = 3'd2;
    #1;
    chk("R1 group 0 after reset", int'(cg_addr), exp_addr(0, 8'h88, 8'h41, 3'd2));
    @(negedge clk);
    rate_check(1'b0, "R1 40-column default");
  endtask

  task automatic t_blue;
    show_cell(8'h41, 8'h10, 3'd0, 1'b1, 0, "blue on black");
    show_cell(8'h41, 8'h10, 3'd5, 1'b1, 0, "blue row 5");
  endtask

  task automatic t_palette;
    show_cell(8'h13, 8'h70, 3'd1, 1'b1, 0, "white on black");
    show_cell(8'hC4, 8'h25, 3'd7, 1'b1, 0, "red on cyan");
    show_cell(8'h7E, 8'h4A, 3'd3, 1'b1, 0, "green on red slot 1");
    show_cell(8'hFF, 8'hF7, 3'd6, 1'b1, 0, "all colour bits");
  endtask

  task automatic t_groups;
    ctrl_write(8'h02);
    show_cell(8'h20, 8'h08, 3'd4, 1'b1, 2, "R4 group 2 slot 9");
    ctrl_write(8'h03);
    show_cell(8'h99, 8'h8C, 3'd2, 1'b1, 3, "R4 group 3 slot 15");
  endtask

  task automatic t_bank;
    int a0, a1;
    ctrl_write(8'h01);
    char_code = 8'h55; glyph_row = 3'd3; char_attr = 8'h00;
    #1 a0 = int'(cg_addr);
    char_attr = 8'h08;
    #1 a1 = int'(cg_addr);
    chk("R3 bank half step", a1 - a0, 2048);
    chk("R3 lower half address", a0, exp_addr(1, 8'h00, 8'h55, 3'd3));
    char_attr = 8'h80;
    #1 a0 = int'(cg_addr);
    char_attr = 8'h88;
    #1 a1 = int'(cg_addr);
    chk("R3 second font half step", a1 - a0, 2048);
    @(negedge clk);
    show_cell(8'h55, 8'h08, 3'd3, 1'b1, 1, "R3 upper half cell");
  endtask

  task automatic t_inactive;
    show_cell(8'hA5, 8'h70, 3'd0, 1'b0, 1, "R8 outside area");
    show_cell(8'hA5, 8'h07, 3'd1, 1'b0, 1, "R8 outside area bg");
  endtask

  task automatic t_wide;
    ctrl_write(8'h80);
    rate_check(1'b1, "80-column");
    show_cell(8'h3C, 8'h10, 3'd2, 1'b1, 0, "80-column cell");
    ctrl_write(8'hFE); // R4: bits 6:2 must not matter
    rate_check(1'b1, "R4 ignored bits keep 80-column");
    show_cell(8'h01, 8'h00, 3'd0, 1'b1, 2, "R4 ignored bits group 2");
    ctrl_write(8'h00);
    rate_check(1'b0, "back to 40-column");
    show_cell(8'h62, 8'h61, 3'd7, 1'b1, 0, "40-column again");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_blue;
    t_palette;
    t_groups;
    t_bank;
    t_inactive;
    t_wide;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule